// File: doc/BRIEF.md
# NAND Command and Address Sequencer

This block turns a single command request into the complete set of bus cycles that a raw NAND flash device needs. A request names an opcode and, optionally, a column and a page address. It also says whether the device has a 16-bit data bus and whether it is larger than 32 MiB. The sequencer emits the command-latch bytes and the address-latch bytes, each with its own write strobe. It then handles the ready/busy line in the way the opcode demands: it returns at once, waits a bounded time while holding chip enable low, or waits without limit. It signals completion with a single-cycle `done` pulse.

The sequencer adds a read-pointer prefix in front of a sequential-data-input command, and picks that prefix from the column range. It halves the column for 16-bit parts. It adds a third page-address byte for large parts. After the address is latched it leaves a settle gap. It always waits the write-to-busy delay before it samples ready/busy. All delays are clock-cycle counts derived from a clock-frequency parameter.

Top module: `nand_cmd_seq`

## Requirements
- R1: `req_ready` is high only while the sequencer is idle. A `req_valid` seen while `req_ready` is low is ignored and emits no bus cycle. `done` is high for exactly one cycle per accepted request, and `req_ready` returns high on the following cycle.
- R2: Command bytes are written with CLE high and ALE low. At least one cycle with both CLE and ALE low separates the last command byte from the first address byte, and the two are never high together.
- R3: For opcode 0x80 (sequential input), a prefix command byte precedes the opcode. If column >= `PAGE_BYTES`, the prefix is 0x50 and the column is reduced by `PAGE_BYTES`. Otherwise, if column < 256, the prefix is 0x00 and the column is unchanged. Otherwise the prefix is 0x01 and the column is reduced by 256.
- R4: Address bytes are sent only if a column or a page is supplied. ALE stays high across all of them, and the order is: column byte, page[7:0], page[15:8], then page[19:16] with the upper nibble zero.
- R5: With `req_wide` set, the column (after any R3 adjustment) is shifted right by one before its low byte is sent.
- R6: The page[19:16] address byte is sent only when `req_large` is set.
- R7: For read opcodes 0x00, 0x01 and 0x50 with a page supplied, nCE is held low from the second page byte until the wait ends. It is released in the cycle that `done` is high.
- R8: The held read wait ends on the first cycle that ready/busy is high, or after `READ_STEPS`×`STEP_NS` worth of cycles of busy. Its total span from the fall of ALE to `done` is SETTLE+TWB+1 cycles when the part is already ready, and SETTLE+TWB+LIMIT cycles on timeout.
- R9: Opcodes 0x10, 0x60, 0xD0, 0x80 and 0x70 finish without sampling ready/busy; `done` follows the settle gap (or the CLE release when there is no address).
- R10: All other opcodes, including 0xFF and a read without a page, wait TWB cycles and then wait without limit until ready/busy is high. `done` follows one cycle after ready is seen.
- R11: After ALE falls, a settle gap of `SETTLE_NS` worth of cycles passes with nCE high (unless R7 holds it) before any further step.
- R12: Each byte is driven with output enable high and nCE low. nWE is low for `STROBE_CYC` cycles and then high for `STROBE_CYC` cycles, and data bits [15:8] are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_opcode | input | 8 | Command opcode |
| req_col_en | input | 1 | Column supplied |
| req_col | input | COL_W | Column address in bytes |
| req_page_en | input | 1 | Page address supplied |
| req_page | input | PAGE_W | Page address |
| req_wide | input | 1 | Device has a 16-bit bus |
| req_large | input | 1 | Device larger than 32 MiB |
| done | output | 1 | One-cycle completion pulse |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_nce | output | 1 | Chip enable, active low |
| nand_nwe | output | 1 | Write strobe, active low |
| nand_dq_o | output | 16 | Data bus output |
| nand_dq_oe | output | 1 | Data bus output enable |
| nand_rb | input | 1 | Ready/busy, high when ready |

## Verification
A request is taken on the clock edge where `req_valid` meets `req_ready`, and the first nWE low phase appears on the next cycle. Each byte then lasts 2×`STROBE_CYC` cycles. The bench samples every output on the falling clock edge, half a cycle after it settles. It logs each byte on the first sample with nWE low, and times each low run of nWE. The wait spans are counted in samples from the first sample with ALE low up to the sample where `done` is high: exactly SETTLE, SETTLE+TWB+1 or SETTLE+TWB+LIMIT. For the unbounded wait, the bench checks that no `done` appears while busy is held, and that `done` is seen no later than two samples after ready rises.

// File: rtl/nseq_pkg.sv
// Shared opcode values, controller states and opcode classifiers for the
// NAND command sequencer. Assumes standard small/large-page opcode values.
package nseq_pkg;

    localparam logic [7:0] OP_READ_A    = 8'h00;
    localparam logic [7:0] OP_READ_B    = 8'h01;
    localparam logic [7:0] OP_READ_SPR  = 8'h50;
    localparam logic [7:0] OP_SEQ_IN    = 8'h80;
    localparam logic [7:0] OP_PROG      = 8'h10;
    localparam logic [7:0] OP_ERASE_SET = 8'h60;
    localparam logic [7:0] OP_ERASE_GO  = 8'hD0;
    localparam logic [7:0] OP_STATUS    = 8'h70;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CMD,
        ST_CLE_OFF,
        ST_ADDR,
        ST_SETTLE,
        ST_TWB,
        ST_HOLD_WAIT,
        ST_FREE_WAIT,
        ST_DONE
    } seq_state_t;

    // True for the three read-pointer opcodes.
    function automatic logic is_read_op(input logic [7:0] op);
        return (op == OP_READ_A) || (op == OP_READ_B) || (op == OP_READ_SPR);
    endfunction

    // True for opcodes that finish without touching ready/busy.
    function automatic logic is_nowait_op(input logic [7:0] op);
        return (op == OP_PROG) || (op == OP_ERASE_SET) || (op == OP_ERASE_GO) ||
               (op == OP_SEQ_IN) || (op == OP_STATUS);
    endfunction

endpackage

// File: rtl/nseq_prefix.sv
// Prefix selector and column shaper. Purely combinational.
// For the sequential-input opcode it picks the read-pointer prefix from the
// column range and rebases the column; then it halves the column for 16-bit
// parts. Assumes PAGE_BYTES fits in COL_W bits.
module nseq_prefix #(
    parameter int COL_W      = 12,
    parameter int PAGE_BYTES = 512
) (
    input  logic [7:0]       opcode,
    input  logic [COL_W-1:0] col,
    input  logic             wide,
    output logic             pre_valid,
    output logic [7:0]       pre_byte,
    output logic [7:0]       col_byte
);
    import nseq_pkg::*;

    localparam logic [COL_W-1:0] PG_LIM   = COL_W'(PAGE_BYTES);
    localparam logic [COL_W-1:0] HALF_LIM = COL_W'(256);

    logic [COL_W-1:0] col_adj;
    logic [COL_W-1:0] col_sh;

    // Choose prefix and rebase the column by range.
    always_comb begin
        pre_valid = (opcode == OP_SEQ_IN);
        pre_byte  = OP_READ_A;
        col_adj   = col;
        if (pre_valid) begin
            if (col >= PG_LIM) begin
                pre_byte = OP_READ_SPR;
                col_adj  = col - PG_LIM;
            end else if (col < HALF_LIM) begin
                pre_byte = OP_READ_A;
            end else begin
                pre_byte = OP_READ_B;
                col_adj  = col - HALF_LIM;
            end
        end
    end

    // Halve the column on a 16-bit bus and keep one address byte.
    always_comb begin
        col_sh   = wide ? (col_adj >> 1) : col_adj;
        col_byte = col_sh[7:0];
    end

endmodule

// File: rtl/nseq_timer.sv
// Loadable down-counter used for every wait of the sequencer.
// A load of N-1 followed by run keeps the caller in its state for N cycles.
module nseq_timer #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    // Load on request, else count down to zero and stop.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (load)           cnt_q <= load_val;
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

endmodule

// File: rtl/nseq_slotsel.sv
// Lowest-set-bit picker over the pending byte slots. Combinational.
// Assumes N is at least 2.
module nseq_slotsel #(
    parameter int N     = 6,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     mask,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan downward so the lowest pending slot wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (mask[i]) idx = IDX_W'(i);
        end
        any = |mask;
    end

endmodule

// File: rtl/nand_cmd_seq.sv
// NAND command and address sequencer (top).
// Takes one request while idle and plays it out: command bytes under CLE, a
// CLE release cycle, address bytes under ALE, a settle gap, then the
// opcode-specific ready/busy handling, then a one-cycle done pulse.
// Assumes nand_rb is already synchronous to clk.
module nand_cmd_seq #(
    parameter int CLK_MHZ    = 100,
    parameter int STROBE_CYC = 2,
    parameter int PAGE_BYTES = 512,
    parameter int COL_W      = 12,
    parameter int PAGE_W     = 20,
    parameter int TWB_NS     = 100,
    parameter int SETTLE_NS  = 1000,
    parameter int STEP_NS    = 1000,
    parameter int READ_STEPS = 30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_opcode,
    input  logic              req_col_en,
    input  logic [COL_W-1:0]  req_col,
    input  logic              req_page_en,
    input  logic [PAGE_W-1:0] req_page,
    input  logic              req_wide,
    input  logic              req_large,
    output logic              done,
    output logic              nand_cle,
    output logic              nand_ale,
    output logic              nand_nce,
    output logic              nand_nwe,
    output logic [15:0]       nand_dq_o,
    output logic              nand_dq_oe,
    input  logic              nand_rb
);
    import nseq_pkg::*;

    localparam int NS_TWB    = (TWB_NS * CLK_MHZ + 999) / 1000;
    localparam int NS_SETTLE = (SETTLE_NS * CLK_MHZ + 999) / 1000;
    localparam int NS_STEP   = (STEP_NS * CLK_MHZ + 999) / 1000;
    localparam int TWB_CYC    = (NS_TWB < 1) ? 1 : NS_TWB;
    localparam int SETTLE_CYC = (NS_SETTLE < 1) ? 1 : NS_SETTLE;
    localparam int STEP_CYC   = (NS_STEP < 1) ? 1 : NS_STEP;
    localparam int LIMIT_RAW  = READ_STEPS * STEP_CYC;
    localparam int LIMIT_CYC  = (LIMIT_RAW < 1) ? 1 : LIMIT_RAW;
    localparam int MAX_AB     = (LIMIT_CYC > SETTLE_CYC) ? LIMIT_CYC : SETTLE_CYC;
    localparam int TMR_MAX    = (MAX_AB > TWB_CYC) ? MAX_AB : TWB_CYC;
    localparam int TMR_W      = $clog2(TMR_MAX + 1);
    localparam int BYTE_CYC   = 2 * STROBE_CYC;
    localparam int BC_W       = (BYTE_CYC > 2) ? $clog2(BYTE_CYC) : 1;
    localparam int N_SLOT     = 6;
    localparam int SLOT_W     = $clog2(N_SLOT);
    localparam int SLOT_PG_LO = 3;

    seq_state_t         state_q, state_d;
    logic [N_SLOT-1:0]  mask_q;
    logic [7:0]         slot_q [N_SLOT];
    logic [7:0]         op_q;
    logic               hold_req_q;
    logic               force_hold_q;
    logic [BC_W-1:0]    bcnt_q;

    logic               pre_valid;
    logic [7:0]         pre_byte;
    logic [7:0]         col_byte;
    logic [SLOT_W-1:0]  cur;
    logic               any_pending;
    logic               tmr_load;
    logic [TMR_W-1:0]   tmr_val;
    logic               tmr_zero;
    logic               writing;
    logic               byte_end;
    logic               accept;
    logic [N_SLOT-1:0]  rest;

    nseq_prefix #(
        .COL_W      (COL_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_prefix (
        .opcode    (req_opcode),
        .col       (req_col),
        .wide      (req_wide),
        .pre_valid (pre_valid),
        .pre_byte  (pre_byte),
        .col_byte  (col_byte)
    );

    nseq_slotsel #(
        .N     (N_SLOT),
        .IDX_W (SLOT_W)
    ) u_slotsel (
        .mask (mask_q),
        .idx  (cur),
        .any  (any_pending)
    );

    nseq_timer #(
        .W (TMR_W)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    assign writing  = (state_q == ST_CMD) || (state_q == ST_ADDR);
    assign byte_end = (bcnt_q == BC_W'(BYTE_CYC - 1));
    assign accept   = (state_q == ST_IDLE) && req_valid;
    assign rest     = mask_q & ~(N_SLOT'(1) << cur);

    // Next-state selection and timer loads for each wait state.
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_CMD;
            ST_CMD: if (byte_end && (rest[1:0] == 2'b00)) state_d = ST_CLE_OFF;
            ST_CLE_OFF: begin
                if (mask_q[N_SLOT-1:2] != '0) begin
                    state_d = ST_ADDR;
                end else if (is_nowait_op(op_q)) begin
                    state_d = ST_DONE;
                end else begin
                    state_d  = ST_TWB;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(TWB_CYC - 1);
                end
            end
            ST_ADDR: if (byte_end && (rest == '0)) begin
                state_d  = ST_SETTLE;
                tmr_load = 1'b1;
                tmr_val  = TMR_W'(SETTLE_CYC - 1);
            end
            ST_SETTLE: if (tmr_zero) begin
                if (is_nowait_op(op_q)) begin
                    state_d = ST_DONE;
                end else begin
                    state_d  = ST_TWB;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(TWB_CYC - 1);
                end
            end
            ST_TWB: if (tmr_zero) begin
                if (force_hold_q) begin
                    state_d  = ST_HOLD_WAIT;
                    tmr_load = 1'b1;
                    tmr_val  = TMR_W'(LIMIT_CYC - 1);
                end else begin
                    state_d = ST_FREE_WAIT;
                end
            end
            ST_HOLD_WAIT: if (nand_rb || tmr_zero) state_d = ST_DONE;
            ST_FREE_WAIT: if (nand_rb) state_d = ST_DONE;
            ST_DONE:      state_d = ST_IDLE;
            default:      state_d = ST_IDLE;
        endcase
    end

    // State register and request capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_IDLE;
            op_q       <= '0;
            hold_req_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                op_q       <= req_opcode;
                hold_req_q <= is_read_op(req_opcode) && req_page_en;
            end
        end
    end

    // Byte slot contents, written once per request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOT; i++) slot_q[i] <= '0;
        end else if (accept) begin
            slot_q[0] <= pre_byte;
            slot_q[1] <= req_opcode;
            slot_q[2] <= col_byte;
            slot_q[3] <= req_page[7:0];
            slot_q[4] <= req_page[15:8];
            slot_q[5] <= {4'b0000, req_page[19:16]};
        end
    end

    // Pending-slot mask: set on accept, one bit retired per finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (accept) begin
            mask_q <= {req_page_en && req_large, req_page_en, req_page_en,
                       req_col_en, 1'b1, pre_valid};
        end else if (writing && byte_end && any_pending) begin
            mask_q[cur] <= 1'b0;
        end
    end

    // Strobe phase counter within one byte.
    always_ff @(posedge clk) begin
        if (!rst_n || !writing || byte_end) bcnt_q <= '0;
        else                                bcnt_q <= bcnt_q + 1'b1;
    end

    // Chip-enable hold for reads: set as the second page byte begins, dropped at done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            force_hold_q <= 1'b0;
        end else if (state_q == ST_ADDR && byte_end && hold_req_q &&
                     cur == SLOT_W'(SLOT_PG_LO)) begin
            force_hold_q <= 1'b1;
        end else if (state_d == ST_DONE) begin
            force_hold_q <= 1'b0;
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign done       = (state_q == ST_DONE);
    assign nand_cle   = (state_q == ST_CMD);
    assign nand_ale   = (state_q == ST_ADDR);
    assign nand_nwe   = !(writing && (bcnt_q < BC_W'(STROBE_CYC)));
    assign nand_nce   = !(writing || force_hold_q);
    assign nand_dq_oe = writing;
    assign nand_dq_o  = writing ? {8'h00, slot_q[cur]} : 16'h0000;

endmodule

// File: rtl/nand_cmd_seq_chk.sv
// Protocol checker for the NAND command sequencer, attached by bind.
// Watches the request handshake and the bus strobes only.
module nand_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic req_valid,
    input logic req_ready,
    input logic done,
    input logic nand_cle,
    input logic nand_ale,
    input logic nand_nce,
    input logic nand_nwe,
    input logic nand_dq_oe
);
    assert_cle_ale_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(nand_cle && nand_ale));

    assert_done_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_then_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    assert_accept_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    assert_strobe_driven_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !nand_nwe |-> (nand_dq_oe && !nand_nce));

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (nand_nce && nand_nwe && !nand_cle && !nand_ale));

endmodule

bind nand_cmd_seq nand_cmd_seq_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done       (done),
    .nand_cle   (nand_cle),
    .nand_ale   (nand_ale),
    .nand_nce   (nand_nce),
    .nand_nwe   (nand_nwe),
    .nand_dq_oe (nand_dq_oe)
);

// File: tb/nand_cmd_seq_tb.sv
// Directed bench for nand_cmd_seq: one task per scenario, each checks itself.
module nand_cmd_seq_tb;

    localparam int STB      = 2;
    localparam int SETTLE_C = 100;   // 1000 ns at 100 MHz
    localparam int TWB_C    = 10;    // 100 ns at 100 MHz
    localparam int LIMIT_C  = 3000;  // 30 steps of 1000 ns
    localparam int WD_CYC   = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [7:0]  req_opcode = '0;
    logic        req_col_en = 1'b0;
    logic [11:0] req_col = '0;
    logic        req_page_en = 1'b0;
    logic [19:0] req_page = '0;
    logic        req_wide = 1'b0;
    logic        req_large = 1'b0;
    logic        done;
    logic        nand_cle, nand_ale, nand_nce, nand_nwe, nand_dq_oe;
    logic [15:0] nand_dq_o;
    logic        nand_rb = 1'b1;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    nand_cmd_seq u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_opcode (req_opcode),
        .req_col_en (req_col_en),
        .req_col    (req_col),
        .req_page_en(req_page_en),
        .req_page   (req_page),
        .req_wide   (req_wide),
        .req_large  (req_large),
        .done       (done),
        .nand_cle   (nand_cle),
        .nand_ale   (nand_ale),
        .nand_nce   (nand_nce),
        .nand_nwe   (nand_nwe),
        .nand_dq_o  (nand_dq_o),
        .nand_dq_oe (nand_dq_oe),
        .nand_rb    (nand_rb)
    );

    // Bus monitor state, sampled on falling edges.
    logic [9:0] rec [16];
    int  rec_n = 0;
    int  done_cnt = 0;
    int  bad_strobe = 0, bad_upper = 0, bad_gap = 0, overlap = 0;
    int  low_run = 0, post_cnt = 0, post_lat = -1;
    bit  measuring = 0;
    logic post_nce = 1'b1, nce_at_done = 1'b0;
    logic prev_nwe = 1'b1, prev_cle = 1'b0, prev_ale = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (nand_cle && nand_ale) overlap++;
            if (prev_cle && nand_ale) bad_gap++;
            if (!nand_nwe) begin
                low_run++;
                if (prev_nwe) begin
                    if (rec_n < 16) rec[rec_n] = {nand_cle, nand_ale, nand_dq_o[7:0]};
                    rec_n++;
                    if (nand_dq_o[15:8] != 8'h00 || !nand_dq_oe || nand_nce) bad_upper++;
                end
            end else if (!prev_nwe) begin
                if (low_run != STB) bad_strobe++;
                low_run = 0;
            end
            if (nand_ale) begin
                measuring = 1; post_cnt = 0;
            end else if (measuring) begin
                if (prev_ale) post_nce = nand_nce;
                if (done) begin
                    measuring = 0; post_lat = post_cnt;
                end else begin
                    post_cnt++;
                end
            end
            if (done) begin
                done_cnt++; nce_at_done = nand_nce;
            end
            prev_nwe = nand_nwe; prev_cle = nand_cle; prev_ale = nand_ale;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr();
        @(negedge clk);
        rec_n = 0; post_lat = -1; measuring = 0; post_nce = 1'b1;
    endtask

    task automatic start_req(input logic [7:0] op, input logic ce, input int col,
                             input logic pe, input int pg, input logic w, input logic lg);
        @(negedge clk);
        req_opcode = op; req_col_en = ce; req_col = 12'(col);
        req_page_en = pe; req_page = 20'(pg); req_wide = w; req_large = lg;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic wait_done(input int start_cnt, input int max_cyc);
        for (int i = 0; i < max_cyc && done_cnt == start_cnt; i++) @(negedge clk);
    endtask

    // Compare a recorded byte as {cle, ale, data}.
    task automatic chk_byte(input string tag, input int i, input logic c,
                            input logic a, input logic [7:0] d);
        chk(tag, int'(rec[i]), int'({c, a, d}));
    endtask

    task automatic t_reset_state();
        chk("R1 ready after reset", int'(req_ready), 1);
        chk("R1 bus idle after reset", int'({nand_nce, nand_nwe, nand_cle, nand_ale, done}), 'b11000);
    endtask

    task automatic t_seqin_low();
        int d0;
        clr(); nand_rb = 1'b0; d0 = done_cnt;
        start_req(8'h80, 1, 10, 1, 'h1234, 0, 0);
        wait_done(d0, 1000);
        chk("R3 low prefix count", rec_n, 5);
        chk_byte("R3 prefix 00", 0, 1, 0, 8'h00);
        chk_byte("R2 opcode under CLE", 1, 1, 0, 8'h80);
        chk_byte("R4 column byte", 2, 0, 1, 8'h0A);
        chk_byte("R4 page low", 3, 0, 1, 8'h34);
        chk_byte("R4 page mid", 4, 0, 1, 8'h12);
        chk("R9 no wait on busy", done_cnt - d0, 1);
        chk("R11 settle span", post_lat, SETTLE_C);
        chk("R11 nce high in settle", int'(post_nce), 1);
        nand_rb = 1'b1;
    endtask

    task automatic t_seqin_high();
        int d0;
        clr(); d0 = done_cnt;
        start_req(8'h80, 1, 300, 0, 0, 0, 0);
        wait_done(d0, 1000);
        chk("R3 high prefix count", rec_n, 3);
        chk_byte("R3 prefix 01", 0, 1, 0, 8'h01);
        chk_byte("R3 column minus 256", 2, 0, 1, 8'h2C);
    endtask

    task automatic t_seqin_oob_wide();
        int d0;
        clr(); d0 = done_cnt;
        start_req(8'h80, 1, 520, 0, 0, 1, 0);
        wait_done(d0, 1000);
        chk_byte("R3 prefix 50", 0, 1, 0, 8'h50);
        chk_byte("R5 wide rebased column", 2, 0, 1, 8'h04);
    endtask

    task automatic t_read_ready_large();
        int d0;
        clr(); nand_rb = 1'b1; d0 = done_cnt;
        start_req(8'h00, 1, 'h1FE, 1, 'hABCDE, 1, 1);
        wait_done(d0, 1000);
        chk("R6 large byte count", rec_n, 5);
        chk_byte("R5 wide column", 1, 0, 1, 8'hFF);
        chk_byte("R4 page low", 2, 0, 1, 8'hDE);
        chk_byte("R4 page mid", 3, 0, 1, 8'hBC);
        chk_byte("R6 page high nibble", 4, 0, 1, 8'h0A);
        chk("R7 nce held after ALE", int'(post_nce), 0);
        chk("R8 ready span", post_lat, SETTLE_C + TWB_C + 1);
        chk("R7 nce released at done", int'(nce_at_done), 1);
    endtask

    task automatic t_read_timeout();
        int d0;
        clr(); nand_rb = 1'b0; d0 = done_cnt;
        start_req(8'h50, 1, 0, 1, 5, 0, 0);
        wait_done(d0, 5000);
        chk("R7 spare read nce held", int'(post_nce), 0);
        chk("R8 timeout span", post_lat, SETTLE_C + TWB_C + LIMIT_C);
        chk("R7 nce released after timeout", int'(nce_at_done), 1);
        nand_rb = 1'b1;
    endtask

    task automatic t_reset_op();
        int d0;
        clr(); nand_rb = 1'b0; d0 = done_cnt;
        start_req(8'hFF, 0, 0, 0, 0, 0, 0);
        repeat (2000) @(negedge clk);
        chk("R10 no done while busy", done_cnt - d0, 0);
        chk("R4 no address without col/page", rec_n, 1);
        nand_rb = 1'b1;
        repeat (2) @(negedge clk);
        chk("R10 done after ready", done_cnt - d0, 1);
    endtask

    task automatic t_read_no_page();
        int d0;
        clr(); nand_rb = 1'b0; d0 = done_cnt;
        start_req(8'h01, 1, 3, 0, 0, 0, 0);
        repeat (3000 + SETTLE_C + TWB_C + 50) @(negedge clk);
        chk("R10 read without page waits unbounded", done_cnt - d0, 0);
        nand_rb = 1'b1;
        wait_done(d0, 10);
        chk("R10 read without page completes", done_cnt - d0, 1);
    endtask

    task automatic t_erase();
        int d0;
        clr(); nand_rb = 1'b0; d0 = done_cnt;
        start_req(8'h60, 0, 0, 1, 'h0456, 0, 0);
        wait_done(d0, 1000);
        chk("R4 erase byte count", rec_n, 3);
        chk_byte("R4 erase page low first", 1, 0, 1, 8'h56);
        chk("R9 erase no nce hold", int'(post_nce), 1);
        chk("R9 erase settle only", post_lat, SETTLE_C);
        nand_rb = 1'b1;
    endtask

    task automatic t_busy_ignore();
        int d0;
        clr(); d0 = done_cnt;
        start_req(8'h70, 0, 0, 0, 0, 0, 0);
        chk("R1 busy after accept", int'(req_ready), 0);
        req_opcode = 8'hFF; req_valid = 1'b1;
        @(negedge clk); @(negedge clk);
        req_valid = 1'b0;
        wait_done(d0, 100);
        repeat (20) @(negedge clk);
        chk("R1 one byte only", rec_n, 1);
        chk_byte("R1 status opcode", 0, 1, 0, 8'h70);
        chk("R1 single done", done_cnt - d0, 1);
        chk("R1 ready again", int'(req_ready), 1);
    endtask

    initial begin
        repeat (WD_CYC) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=0", WD_CYC);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_seqin_low();
        t_seqin_high();
        t_seqin_oob_wide();
        t_read_ready_large();
        t_read_timeout();
        t_reset_op();
        t_read_no_page();
        t_erase();
        t_busy_ignore();
        chk("R12 strobe widths", bad_strobe, 0);
        chk("R12 bus driven, upper zero", bad_upper, 0);
        chk("R2 CLE/ALE gap", bad_gap + overlap, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule